// File: doc/BRIEF.md
# Lane-Regularity Register Classifier

This block follows, for every architectural vector register of a SIMT core, whether the value held across the lanes has a simple shape. There are three classes. A register is Uniform when every lane holds the same constant. It is Affine when lane i holds base + i·stride. In every other case it is Unknown. Alongside each class the block keeps a scalar base and a scalar stride. A Uniform register keeps a stride of zero.

Each issued instruction carries:

- an operation class,
- a destination register,
- up to two source registers,
- a 32-bit immediate, which may also be the thread count.

The block reads the classes of the sources and applies algebraic propagation rules. From these it works out the class, base and stride of the result. It writes them back for the destination and reports them one cycle after issue. A skip flag in the same cycle tells the vector datapath that the result is fully described by scalars. The datapath can then leave the vector lanes idle for that instruction.

Top module: `uat_tracker`

## Requirements
- R1: After reset, and for every register not written since then, the register's class is Unknown with base 0 and stride 0. While reset is active and on the first cycle after it, `res_valid` is 0.
- R2: Class encoding on `res_tag` is 2'b00 Unknown, 2'b01 Uniform, 2'b10 Affine; 2'b11 never appears. Operation codes on `issue_op` are 0 no-op, 1 thread-index move, 2 immediate move, 3 add, 4 multiply, 5 add-immediate, 6 load, 7 other. Every valid non-no-op instruction yields `res_valid`=1 exactly one cycle after issue. A no-op yields `res_valid`=0 and writes nothing.
- R3: A thread-index move gives Affine with base 0 and stride 1.
- R4: An immediate move gives Uniform with base equal to the immediate and stride 0.
- R5: Add of two known sources gives Affine if either source is Affine, otherwise Uniform. The base is the sum of the bases and the stride is the sum of the strides, both modulo 2^32. Add with any Unknown source gives Unknown.
- R6: Multiply of Uniform by Uniform gives Uniform with the product of the bases. Affine times Uniform, in either order, gives Affine, with both the base and the stride of the Affine operand multiplied by the Uniform value. Affine times Affine, or any Unknown source, gives Unknown.
- R7: Add-immediate keeps the source class and stride and adds the immediate to the base. An Unknown source stays Unknown.
- R8: Load and other operations always give Unknown, whatever the source classes.
- R9: Every Unknown result is reported and stored with base 0 and stride 0.
- R10: `res_skip` is 1 exactly when a result is valid and its class is Uniform or Affine.
- R11: An instruction issued in the cycle right after a write sees the newly written class of its source. A no-op leaves all stored classes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_op | input | 3 | Operation class code |
| issue_dst | input | 4 | Destination register index |
| issue_src_a | input | 4 | First source register index |
| issue_src_b | input | 4 | Second source register index |
| issue_imm | input | 32 | Immediate or thread-count operand |
| res_valid | output | 1 | Result of the previous cycle's instruction |
| res_dst | output | 4 | Destination register of the result |
| res_tag | output | 2 | Class of the result |
| res_base | output | 32 | Scalar base of the result |
| res_stride | output | 32 | Scalar stride of the result |
| res_skip | output | 1 | Vector execution may be skipped |

## Verification
A stored entry with a corrupted class, base or stride stays hidden until some later instruction reads that register. That instruction's result then shows a wrong class or scalar one cycle after its issue. A wrong class also flips `res_skip` in that same cycle. The bench therefore runs long dependent chains, with a model of all sixteen entries, so that each entry is read back soon after it is written. Back-to-back dependent pairs expose a stale read at once. A lost reset shows on the first read of an unwritten register.

// File: rtl/uat_pkg.sv
package uat_pkg;
  typedef enum logic [1:0] {
    TAG_UNK = 2'b00,
    TAG_UNI = 2'b01,
    TAG_AFF = 2'b10
  } tag_e;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_TID   = 3'd1,
    OP_IMM   = 3'd2,
    OP_ADD   = 3'd3,
    OP_MUL   = 3'd4,
    OP_ADDI  = 3'd5,
    OP_LOAD  = 3'd6,
    OP_OTHER = 3'd7
  } op_e;

  // how the scalar unit forms base and stride
  typedef enum logic [2:0] {
    SC_ZERO,
    SC_TID,
    SC_IMM,
    SC_SUM,
    SC_SCALE_AB,
    SC_SCALE_BA,
    SC_ADDI
  } scsel_e;

  localparam int NUM_RD_PORTS = 2;
endpackage

// File: rtl/uat_tag_file.sv
module uat_tag_file
  import uat_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  tag_e              wtag,
  input  logic [DATA_W-1:0] wbase,
  input  logic [DATA_W-1:0] wstride,
  input  logic [ADDR_W-1:0] raddr  [NUM_RD_PORTS],
  output tag_e              rtag   [NUM_RD_PORTS],
  output logic [DATA_W-1:0] rbase  [NUM_RD_PORTS],
  output logic [DATA_W-1:0] rstride[NUM_RD_PORTS]
);
  // storage arrays without reset so they map onto distributed RAM
  tag_e              tag_mem   [NREG];
  logic [DATA_W-1:0] base_mem  [NREG];
  logic [DATA_W-1:0] stride_mem[NREG];
  // one written-since-reset bit per entry; this is the only reset state
  logic [NREG-1:0]   live;

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[waddr]    <= wtag;
      base_mem[waddr]   <= wbase;
      stride_mem[waddr] <= wstride;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     live <= '0;
    else if (we) live[waddr] <= 1'b1;
  end

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
    always_comb begin
      if (live[raddr[p]]) begin
        rtag[p]    = tag_mem[raddr[p]];
        rbase[p]   = base_mem[raddr[p]];
        rstride[p] = stride_mem[raddr[p]];
      end else begin
        rtag[p]    = TAG_UNK;
        rbase[p]   = '0;
        rstride[p] = '0;
      end
    end
  end

  // R11: a write lands in the entry addressed, visible on the next cycle
  p_write_visible_r11: assert property (@(posedge clk) disable iff (rst)
    we |=> live[$past(waddr)]);
endmodule

// File: rtl/uat_tag_rules.sv
module uat_tag_rules
  import uat_pkg::*;
(
  input  op_e    op,
  input  tag_e   tag_a,
  input  tag_e   tag_b,
  output tag_e   res_tag,
  output scsel_e sel,
  output logic   writes,
  output logic   skip
);
  logic known_a, known_b;

  always_comb begin
    known_a = (tag_a == TAG_UNI) || (tag_a == TAG_AFF);
    known_b = (tag_b == TAG_UNI) || (tag_b == TAG_AFF);
    res_tag = TAG_UNK;
    sel     = SC_ZERO;
    writes  = 1'b1;
    unique case (op)
      OP_NOP: writes = 1'b0;
      OP_TID: begin
        res_tag = TAG_AFF;
        sel     = SC_TID;
      end
      OP_IMM: begin
        res_tag = TAG_UNI;
        sel     = SC_IMM;
      end
      OP_ADD: begin
        if (known_a && known_b) begin
          res_tag = (tag_a == TAG_AFF || tag_b == TAG_AFF) ? TAG_AFF : TAG_UNI;
          sel     = SC_SUM;
        end
      end
      OP_MUL: begin
        if (known_a && tag_b == TAG_UNI) begin
          res_tag = tag_a;
          sel     = SC_SCALE_AB;
        end else if (tag_a == TAG_UNI && tag_b == TAG_AFF) begin
          res_tag = TAG_AFF;
          sel     = SC_SCALE_BA;
        end
      end
      OP_ADDI: begin
        if (known_a) begin
          res_tag = tag_a;
          sel     = SC_ADDI;
        end
      end
      default: ; // load and other: Unknown
    endcase
    skip = writes && (res_tag != TAG_UNK);
  end
endmodule

// File: rtl/uat_scalar_unit.sv
module uat_scalar_unit
  import uat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  scsel_e            sel,
  input  logic [DATA_W-1:0] base_a,
  input  logic [DATA_W-1:0] stride_a,
  input  logic [DATA_W-1:0] base_b,
  input  logic [DATA_W-1:0] stride_b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] stride
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    base   = '0;
    stride = '0;
    unique case (sel)
      SC_TID: stride = ONE;
      SC_IMM: base = imm;
      SC_SUM: begin
        base   = base_a + base_b;
        stride = stride_a + stride_b;
      end
      SC_SCALE_AB: begin
        base   = base_a * base_b;
        stride = stride_a * base_b;
      end
      SC_SCALE_BA: begin
        base   = base_a * base_b;
        stride = stride_b * base_a;
      end
      SC_ADDI: begin
        base   = base_a + imm;
        stride = stride_a;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uat_tracker.sv
module uat_tracker
  import uat_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [2:0]        issue_op,
  input  logic [ADDR_W-1:0] issue_dst,
  input  logic [ADDR_W-1:0] issue_src_a,
  input  logic [ADDR_W-1:0] issue_src_b,
  input  logic [DATA_W-1:0] issue_imm,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_dst,
  output logic [1:0]        res_tag,
  output logic [DATA_W-1:0] res_base,
  output logic [DATA_W-1:0] res_stride,
  output logic              res_skip
);
  op_e               op;
  logic [ADDR_W-1:0] raddr  [NUM_RD_PORTS];
  tag_e              rtag   [NUM_RD_PORTS];
  logic [DATA_W-1:0] rbase  [NUM_RD_PORTS];
  logic [DATA_W-1:0] rstride[NUM_RD_PORTS];
  tag_e              new_tag;
  scsel_e            sel;
  logic              writes, skip;
  logic [DATA_W-1:0] new_base, new_stride;
  logic              we;

  assign op       = op_e'(issue_op);
  assign raddr[0] = issue_src_a;
  assign raddr[1] = issue_src_b;
  assign we       = issue_valid && writes;

  uat_tag_file #(.NREG(NREG), .DATA_W(DATA_W)) u_file (
    .clk(clk), .rst(rst), .we(we), .waddr(issue_dst),
    .wtag(new_tag), .wbase(new_base), .wstride(new_stride),
    .raddr(raddr), .rtag(rtag), .rbase(rbase), .rstride(rstride)
  );

  uat_tag_rules u_rules (
    .op(op), .tag_a(rtag[0]), .tag_b(rtag[1]),
    .res_tag(new_tag), .sel(sel), .writes(writes), .skip(skip)
  );

  uat_scalar_unit #(.DATA_W(DATA_W)) u_scalar (
    .sel(sel), .base_a(rbase[0]), .stride_a(rstride[0]),
    .base_b(rbase[1]), .stride_b(rstride[1]), .imm(issue_imm),
    .base(new_base), .stride(new_stride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_dst    <= '0;
      res_tag    <= TAG_UNK;
      res_base   <= '0;
      res_stride <= '0;
      res_skip   <= 1'b0;
    end else begin
      res_valid  <= we;
      res_dst    <= issue_dst;
      res_tag    <= new_tag;
      res_base   <= new_base;
      res_stride <= new_stride;
      res_skip   <= we && skip;
    end
  end

  // R2: the spare class code never leaves the block
  p_tag_legal_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_tag != 2'b11);
  // R3: a thread-index move is reported as unit-stride affine
  p_tid_affine_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op == 3'd1) |=>
      (res_valid && res_tag == 2'b10 && res_base == '0 && res_stride == 1));
  // R4: uniform results carry no stride
  p_uniform_flat_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_tag == 2'b01) |-> res_stride == '0);
  // R8: loads never produce a regular class
  p_load_unknown_r8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op == 3'd6) |=> (res_valid && res_tag == 2'b00));
  // R9: scalar unit output is zero whenever the rules give Unknown
  p_unknown_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_tag == 2'b00) |-> (res_base == '0 && res_stride == '0));
  // R10: skip only on a valid, regular result
  p_skip_known_r10: assert property (@(posedge clk) disable iff (rst)
    res_skip |-> (res_valid && res_tag != 2'b00));
endmodule

// File: tb/uat_tracker_test.sv
module uat_tracker_test;
  localparam int NREG = 16;
  localparam logic [1:0] T_UNK = 2'b00, T_UNI = 2'b01, T_AFF = 2'b10;
  localparam logic [2:0] O_NOP = 3'd0, O_TID = 3'd1, O_IMM = 3'd2, O_ADD = 3'd3,
                         O_MUL = 3'd4, O_ADDI = 3'd5, O_LOAD = 3'd6, O_OTH = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = '0;
  logic [3:0]  issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
  logic [31:0] issue_imm = '0;
  logic        res_valid, res_skip;
  logic [3:0]  res_dst;
  logic [1:0]  res_tag;
  logic [31:0] res_base, res_stride;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0]  m_tag   [NREG];
  logic [31:0] m_base  [NREG];
  logic [31:0] m_stride[NREG];

  always #4 clk = ~clk;  // 125 MHz

  uat_tracker uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .issue_imm(issue_imm), .res_valid(res_valid), .res_dst(res_dst),
    .res_tag(res_tag), .res_base(res_base), .res_stride(res_stride),
    .res_skip(res_skip)
  );

  task automatic chk(input string req, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      O_TID:  return "R3";
      O_IMM:  return "R4";
      O_ADD:  return "R5";
      O_MUL:  return "R6";
      O_ADDI: return "R7";
      O_NOP:  return "R2";
      default: return "R8";
    endcase
  endfunction

  function automatic bit known(input logic [1:0] t);
    return t == T_UNI || t == T_AFF;
  endfunction

  // expected class, base and stride from the requirements
  function automatic void predict(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                                  input logic [31:0] imm, output logic [1:0] t,
                                  output logic [31:0] bs, output logic [31:0] st);
    logic [1:0] ta = m_tag[a], tb = m_tag[b];
    logic [31:0] ba = m_base[a], bb = m_base[b], sa = m_stride[a], sb = m_stride[b];
    t = T_UNK; bs = 0; st = 0;
    case (op)
      O_TID: begin t = T_AFF; st = 1; end
      O_IMM: begin t = T_UNI; bs = imm; end
      O_ADD: if (known(ta) && known(tb)) begin
        t = (ta == T_AFF || tb == T_AFF) ? T_AFF : T_UNI;
        bs = ba + bb; st = sa + sb;
      end
      O_MUL: begin
        if (ta == T_UNI && tb == T_UNI) begin t = T_UNI; bs = ba * bb; end
        else if (ta == T_AFF && tb == T_UNI) begin t = T_AFF; bs = ba * bb; st = sa * bb; end
        else if (ta == T_UNI && tb == T_AFF) begin t = T_AFF; bs = ba * bb; st = sb * ba; end
      end
      O_ADDI: if (known(ta)) begin t = ta; bs = ba + imm; st = sa; end
      default: ;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [3:0] d, input logic [3:0] a,
                       input logic [3:0] b, input logic [31:0] imm, input string req);
    logic [1:0] et;
    logic [31:0] eb, es;
    bit esk;
    predict(op, a, b, imm, et, eb, es);
    esk = (op != O_NOP) && (et != T_UNK);
    if (op != O_NOP) begin
      m_tag[d] = et; m_base[d] = eb; m_stride[d] = es;
    end
    issue_valid = 1'b1; issue_op = op; issue_dst = d;
    issue_src_a = a; issue_src_b = b; issue_imm = imm;
    @(posedge clk);
    @(negedge clk);
    if (op == O_NOP) begin
      chk({req, " R2"}, res_valid == 1'b0,
          $sformatf("no-op valid act=%0b exp=0", res_valid));
    end else begin
      chk(req, res_valid && res_dst == d && res_tag == et && res_base == eb && res_stride == es,
          $sformatf("op=%0d act v=%0b d=%0d t=%0d b=%0h s=%0h exp v=1 d=%0d t=%0d b=%0h s=%0h",
                    op, res_valid, res_dst, res_tag, res_base, res_stride, d, et, eb, es));
      if (et == T_UNK)
        chk("R9", res_base == 0 && res_stride == 0,
            $sformatf("unknown scalars act b=%0h s=%0h exp 0 0", res_base, res_stride));
      chk("R10", res_skip == esk, $sformatf("skip act=%0b exp=%0b", res_skip, esk));
    end
  endtask

  task automatic do_reset();
    issue_valid = 1'b0;
    rst = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      m_tag[i] = T_UNK; m_base[i] = 0; m_stride[i] = 0;
    end
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R1", res_valid == 1'b0, $sformatf("valid in reset act=%0b exp=0", res_valid));
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", res_valid == 1'b0, $sformatf("valid after reset act=%0b exp=0", res_valid));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1: unwritten registers read as Unknown
    issue(O_ADD, 4'd1, 4'd2, 4'd3, 0, "R1");
    issue(O_ADDI, 4'd4, 4'd9, 4'd0, 32'd7, "R1");
    // directed chain
    issue(O_TID, 4'd0, 4'd0, 4'd0, 0, "R3");
    issue(O_IMM, 4'd1, 4'd0, 4'd0, 32'd5, "R4");
    issue(O_ADD, 4'd2, 4'd0, 4'd1, 0, "R11 R5");     // back-to-back reader
    issue(O_MUL, 4'd3, 4'd2, 4'd1, 0, "R6");
    issue(O_MUL, 4'd4, 4'd1, 4'd2, 0, "R6");
    issue(O_MUL, 4'd5, 4'd2, 4'd2, 0, "R6");
    issue(O_ADD, 4'd6, 4'd2, 4'd2, 0, "R5");
    issue(O_MUL, 4'd7, 4'd1, 4'd1, 0, "R6");
    issue(O_ADDI, 4'd8, 4'd2, 4'd0, 32'd100, "R7");
    issue(O_LOAD, 4'd9, 4'd2, 4'd1, 0, "R8");
    issue(O_LOAD, 4'd10, 4'd1, 4'd1, 0, "R8");
    issue(O_OTH, 4'd11, 4'd0, 4'd1, 0, "R8");
    issue(O_ADDI, 4'd12, 4'd9, 4'd0, 32'd3, "R7");
    issue(O_ADD, 4'd13, 4'd9, 4'd1, 0, "R5");
    issue(O_NOP, 4'd1, 4'd9, 4'd9, 32'd77, "R2");
    issue(O_ADD, 4'd14, 4'd1, 4'd1, 0, "R11");        // r1 untouched by no-op
    issue(O_IMM, 4'd10, 4'd0, 4'd0, 32'hFFFF_FFFF, "R4");
    issue(O_ADD, 4'd15, 4'd10, 4'd1, 0, "R5");        // wraps to 4
    issue(O_ADD, 4'd15, 4'd15, 4'd0, 0, "R11");       // self-overwrite chain
    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 16;
      logic [2:0] op;
      logic [31:0] imm;
      if (r < 3) op = O_TID;
      else if (r < 5) op = O_IMM;
      else if (r < 8) op = O_ADD;
      else if (r < 11) op = O_MUL;
      else if (r < 13) op = O_ADDI;
      else if (r == 13) op = O_LOAD;
      else if (r == 14) op = O_OTH;
      else op = O_NOP;
      imm = ($urandom % 4 == 0) ? $urandom : ($urandom % 64);
      issue(op, 4'($urandom), 4'($urandom), 4'($urandom), imm, req_of(op));
    end
    // R1: reset in mid-run returns all entries to Unknown
    do_reset();
    issue(O_ADD, 4'd3, 4'd0, 4'd1, 0, "R1");
    issue(O_MUL, 4'd4, 4'd2, 4'd7, 0, "R1");
    issue_valid = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule